// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block listens passively to a four-wire SPI bus on which a host talks to a register-based peripheral. Byte deserialisation is done upstream: each completed byte arrives as a strobe together with the byte seen on the host-to-device line and the byte seen on the device-to-host line. The chip-select line, active low and sampled on the monitor's clock, marks where each command frame begins and ends.

When a frame closes, the monitor decodes its first host byte into a 3-bit opcode and a 5-bit register address. It checks the header and the frame length against the rule for that opcode and picks out the data byte of interest. It also keeps a shadow of the two register-bank select bits, so it can flag register accesses made while the bank is still unknown. Results appear as a single-cycle pulse. The monitor never stalls the bus: the byte input has a valid strobe but no ready, because every strobe is accepted. The result output is valid-only, because a passive observer cannot hold back the bus it watches. Downstream logic must take each result in the cycle it is flagged.

Top module: `spi_cmd_monitor`

## Requirements
- R1: At frame end, `res_opcode` carries bits 7:5 of the first host byte and `res_addr` carries bits 4:0 of that byte.
- R2: Opcode 110 raises `warn_unknown_op`. The other seven codes (000 read register, 001 read buffer, 010 write register, 011 write buffer, 100 set bits, 101 clear bits, 111 reset) do not raise it.
- R3: A read-buffer frame whose first byte is not 0x3A, or a write-buffer frame whose first byte is not 0x7A, raises `warn_bad_header`.
- R4: `warn_bad_length` is raised in these cases: a write-register, set-bits or clear-bits frame whose length is not exactly 2 bytes; a read-register frame that is neither 2 nor 3 bytes; a reset frame that is not exactly 1 byte. Buffer frames of any length never raise it, and neither does opcode 110.
- R5: For a read-register frame, `res_data` is the device byte in position 1 when the frame is 2 bytes long, and the device byte in position 2 when it is 3 or more bytes long. For a read-buffer frame, `res_data` is the device byte in position 1. With fewer bytes than needed, `res_data` is 0.
- R6: For write-register, write-buffer, set-bits and clear-bits frames, `res_data` is the host byte in position 1 (0 if the frame has only 1 byte). For reset and opcode 110 frames, `res_data` is 0.
- R7: A write-register frame of valid length addressed to `BANK_REG_ADDR` loads both bank bits from bits 1:0 of its data byte and marks both bits known. `bank` equals bit1×2+bit0.
- R8: A set-bits or clear-bits frame of valid length addressed to `BANK_REG_ADDR` sets (or clears) each bank bit whose mask bit (data bit 0 or 1) is 1, and marks only those bits known. `bank_known` is high only when both bits are known.
- R9: After reset `bank_known` is 0. A read-register, write-register, set-bits or clear-bits frame of valid length raises `warn_bank_unknown` when the bank was not fully known before that frame.
- R10: A frame with no byte strobes between chip-select falling and rising produces no result pulse.
- R11: `res_count` reports the number of bytes in the frame, saturating at 255.
- R12: `res_valid` is high for exactly one cycle: the cycle after the first clock edge that samples `cs_n` high after a frame. Byte strobes while `cs_n` is high are ignored. Warning outputs are 0 whenever `res_valid` is 0.
- R13: A frame that raises `warn_bad_length` changes neither `bank` nor `bank_known`, and raises no `warn_bank_unknown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Bus chip select, active low |
| byte_valid | input | 1 | Strobe: one completed byte on both lines |
| mosi_byte | input | 8 | Byte sent by the host |
| miso_byte | input | 8 | Byte returned by the device |
| res_valid | output | 1 | One-cycle frame result pulse |
| res_opcode | output | 3 | Decoded opcode |
| res_addr | output | 5 | Decoded register address |
| res_data | output | 8 | Selected data byte |
| res_count | output | CNT_W | Frame byte count, saturating |
| bank | output | 2 | Shadowed bank number |
| bank_known | output | 1 | Both bank bits learned |
| warn_unknown_op | output | 1 | Opcode 110 seen |
| warn_bad_header | output | 1 | Buffer header not exact |
| warn_bad_length | output | 1 | Length breaks opcode rule |
| warn_bank_unknown | output | 1 | Register access with unknown bank |

## Verification
The bench sweeps all 256 header bytes across frame lengths 1 to 4, and a reference model tracks the bank shadow as the sweep proceeds. If the design swapped the dummy and data bytes on a 3-byte read, the sweep would see the wrong byte at position 2. The same sweep exposes a length rule that lets a 3-byte write through, and a bank update from a badly sized frame, because either one moves the bank away from the model. Directed frames then target the remaining corners. A clear-bits frame alone leaves the bank partly known, so a design that treats one learned bit as full knowledge fails there. A 300-byte buffer transfer must report 255 rather than a wrapped 44. An empty frame must give no pulse, and a stray strobe outside chip select must not inflate the count.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  typedef enum logic [2:0] {
    OP_RD_REG  = 3'b000,
    OP_RD_BUF  = 3'b001,
    OP_WR_REG  = 3'b010,
    OP_WR_BUF  = 3'b011,
    OP_SET_BIT = 3'b100,
    OP_CLR_BIT = 3'b101,
    OP_SPARE   = 3'b110,
    OP_RESET   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_LOAD = 2'd1,
    BK_SET  = 2'd2,
    BK_CLR  = 2'd3
  } bank_op_e;

  localparam logic [7:0] RD_BUF_HDR = 8'h3A;
  localparam logic [7:0] WR_BUF_HDR = 8'h7A;

  typedef struct packed {
    logic unknown_op;
    logic bad_header;
    logic bad_length;
    logic bank_unknown;
  } warn_t;

endpackage

// File: rtl/spi_mon_framer.sv
module spi_mon_framer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             byte_valid,
  input  logic [7:0]       mosi_byte,
  input  logic [7:0]       miso_byte,
  output logic             frame_end,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       hdr,
  output logic [7:0]       mosi1,
  output logic [7:0]       miso1,
  output logic [7:0]       miso2
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] IDX0    = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX1    = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX2    = CNT_W'(2);

  logic cs_q;
  logic take;

  assign take      = byte_valid && !cs_n;
  assign frame_end = !cs_q && cs_n && (cnt != IDX0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      cnt  <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        cnt <= '0;
      end else if (take && (cnt != CNT_MAX)) begin
        cnt <= cnt + IDX1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr   <= '0;
      mosi1 <= '0;
      miso1 <= '0;
      miso2 <= '0;
    end else if (take) begin
      if (cnt == IDX0) hdr <= mosi_byte;
      if (cnt == IDX1) begin
        mosi1 <= mosi_byte;
        miso1 <= miso_byte;
      end
      if (cnt == IDX2) miso2 <= miso_byte;
    end
  end

endmodule

// File: rtl/spi_mon_classifier.sv
module spi_mon_classifier
  import spi_mon_pkg::*;
#(
  parameter int         CNT_W         = 8,
  parameter int         BANK_BITS     = 2,
  parameter logic [4:0] BANK_REG_ADDR = 5'h1F
) (
  input  logic [CNT_W-1:0]     cnt,
  input  logic [7:0]           hdr,
  input  logic [7:0]           mosi1,
  input  logic [7:0]           miso1,
  input  logic [7:0]           miso2,
  input  logic                 bank_full,
  output op_e                  opcode,
  output logic [4:0]           addr,
  output logic [7:0]           data,
  output warn_t                warn,
  output bank_op_e             bank_op,
  output logic [BANK_BITS-1:0] bank_val
);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] L3 = CNT_W'(3);

  logic len_ok;
  logic reg_access;
  logic has2;
  logic has3;

  assign opcode = op_e'(hdr[7:5]);
  assign addr   = hdr[4:0];
  assign has2   = cnt >= L2;
  assign has3   = cnt >= L3;

  always_comb begin
    unique case (opcode)
      OP_RD_REG:                        len_ok = (cnt == L2) || (cnt == L3);
      OP_WR_REG, OP_SET_BIT, OP_CLR_BIT: len_ok = (cnt == L2);
      OP_RESET:                         len_ok = (cnt == L1);
      default:                          len_ok = 1'b1;
    endcase
  end

  always_comb begin
    unique case (opcode)
      OP_RD_REG:                         data = has3 ? miso2 : (has2 ? miso1 : 8'h00);
      OP_RD_BUF:                         data = has2 ? miso1 : 8'h00;
      OP_WR_REG, OP_WR_BUF,
      OP_SET_BIT, OP_CLR_BIT:            data = has2 ? mosi1 : 8'h00;
      default:                           data = 8'h00;
    endcase
  end

  assign reg_access = len_ok && ((opcode == OP_RD_REG) || (opcode == OP_WR_REG) ||
                                 (opcode == OP_SET_BIT) || (opcode == OP_CLR_BIT));

  always_comb begin
    warn.unknown_op   = (opcode == OP_SPARE);
    warn.bad_header   = ((opcode == OP_RD_BUF) && (hdr != RD_BUF_HDR)) ||
                        ((opcode == OP_WR_BUF) && (hdr != WR_BUF_HDR));
    warn.bad_length   = !len_ok;
    warn.bank_unknown = reg_access && !bank_full;
  end

  always_comb begin
    bank_op  = BK_NONE;
    bank_val = mosi1[BANK_BITS-1:0];
    if (len_ok && (addr == BANK_REG_ADDR)) begin
      unique case (opcode)
        OP_WR_REG:  bank_op = BK_LOAD;
        OP_SET_BIT: bank_op = BK_SET;
        OP_CLR_BIT: bank_op = BK_CLR;
        default:    bank_op = BK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spi_mon_bank.sv
module spi_mon_bank
  import spi_mon_pkg::*;
#(
  parameter int BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  bank_op_e             upd_op,
  input  logic [BANK_BITS-1:0] upd_val,
  output logic [BANK_BITS-1:0] bank,
  output logic                 bank_full
);
  logic [BANK_BITS-1:0] known;

  for (genvar i = 0; i < BANK_BITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[i]  <= 1'b0;
        known[i] <= 1'b0;
      end else if (upd_en) begin
        unique case (upd_op)
          BK_LOAD: begin
            bank[i]  <= upd_val[i];
            known[i] <= 1'b1;
          end
          BK_SET: if (upd_val[i]) begin
            bank[i]  <= 1'b1;
            known[i] <= 1'b1;
          end
          BK_CLR: if (upd_val[i]) begin
            bank[i]  <= 1'b0;
            known[i] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign bank_full = &known;

endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
  import spi_mon_pkg::*;
#(
  parameter int         CNT_W         = 8,
  parameter int         BANK_BITS     = 2,
  parameter logic [4:0] BANK_REG_ADDR = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             byte_valid,
  input  logic [7:0]       mosi_byte,
  input  logic [7:0]       miso_byte,
  output logic             res_valid,
  output logic [2:0]       res_opcode,
  output logic [4:0]       res_addr,
  output logic [7:0]       res_data,
  output logic [CNT_W-1:0] res_count,
  output logic [BANK_BITS-1:0] bank,
  output logic             bank_known,
  output logic             warn_unknown_op,
  output logic             warn_bad_header,
  output logic             warn_bad_length,
  output logic             warn_bank_unknown
);
  logic             frame_end;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       hdr, mosi1, miso1, miso2;
  op_e              opcode;
  logic [4:0]       addr;
  logic [7:0]       data;
  warn_t            warn, warn_q;
  bank_op_e         bank_op;
  logic [BANK_BITS-1:0] bank_val;

  spi_mon_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
    .mosi_byte(mosi_byte), .miso_byte(miso_byte), .frame_end(frame_end),
    .cnt(cnt), .hdr(hdr), .mosi1(mosi1), .miso1(miso1), .miso2(miso2)
  );

  spi_mon_classifier #(
    .CNT_W(CNT_W), .BANK_BITS(BANK_BITS), .BANK_REG_ADDR(BANK_REG_ADDR)
  ) u_class (
    .cnt(cnt), .hdr(hdr), .mosi1(mosi1), .miso1(miso1), .miso2(miso2),
    .bank_full(bank_known), .opcode(opcode), .addr(addr), .data(data),
    .warn(warn), .bank_op(bank_op), .bank_val(bank_val)
  );

  spi_mon_bank #(.BANK_BITS(BANK_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .upd_en(frame_end), .upd_op(bank_op),
    .upd_val(bank_val), .bank(bank), .bank_full(bank_known)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_opcode <= '0;
      res_addr   <= '0;
      res_data   <= '0;
      res_count  <= '0;
      warn_q     <= '0;
    end else begin
      res_valid <= frame_end;
      warn_q    <= frame_end ? warn : '0;
      if (frame_end) begin
        res_opcode <= opcode;
        res_addr   <= addr;
        res_data   <= data;
        res_count  <= cnt;
      end
    end
  end

  assign warn_unknown_op   = warn_q.unknown_op;
  assign warn_bad_header   = warn_q.bad_header;
  assign warn_bad_length   = warn_q.bad_length;
  assign warn_bank_unknown = warn_q.bank_unknown;

endmodule

// File: rtl/spi_mon_checker.sv
module spi_mon_checker #(
  parameter int         CNT_W         = 8,
  parameter int         BANK_BITS     = 2,
  parameter logic [4:0] BANK_REG_ADDR = 5'h1F
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 res_valid,
  input logic [2:0]           res_opcode,
  input logic [4:0]           res_addr,
  input logic [CNT_W-1:0]     res_count,
  input logic [BANK_BITS-1:0] bank,
  input logic                 bank_known,
  input logic                 warn_unknown_op,
  input logic                 warn_bad_header,
  input logic                 warn_bad_length,
  input logic                 warn_bank_unknown
);
  logic [3:0] warns;
  assign warns = {warn_unknown_op, warn_bad_header, warn_bad_length, warn_bank_unknown};

  assert_pulse_after_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_warn_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (warns == 4'b0000));

  assert_nonzero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count != '0));

  assert_bank_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(bank) && $stable(bank_known)));

  assert_load_learns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_opcode == 3'b010 && res_addr == BANK_REG_ADDR && !warn_bad_length)
      |-> bank_known);

  assert_spare_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_opcode == 3'b110) |-> warn_unknown_op);

  assert_reset_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_opcode == 3'b111 && res_count != CNT_W'(1)) |-> warn_bad_length);

  assert_badlen_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    warn_bad_length |-> (!warn_bank_unknown && $stable(bank) && $stable(bank_known)));

endmodule

bind spi_cmd_monitor spi_mon_checker #(
  .CNT_W(CNT_W), .BANK_BITS(BANK_BITS), .BANK_REG_ADDR(BANK_REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .res_valid(res_valid),
  .res_opcode(res_opcode), .res_addr(res_addr), .res_count(res_count),
  .bank(bank), .bank_known(bank_known), .warn_unknown_op(warn_unknown_op),
  .warn_bad_header(warn_bad_header), .warn_bad_length(warn_bad_length),
  .warn_bank_unknown(warn_bank_unknown)
);

// File: tb/sim_spi_cmd_monitor.sv
module sim_spi_cmd_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] mosi_byte = 8'h00;
  logic [7:0] miso_byte = 8'h00;
  logic       res_valid;
  logic [2:0] res_opcode;
  logic [4:0] res_addr;
  logic [7:0] res_data;
  logic [7:0] res_count;
  logic [1:0] bank;
  logic       bank_known;
  logic       warn_unknown_op, warn_bad_header, warn_bad_length, warn_bank_unknown;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] fm [0:299];
  logic [7:0] fs [0:299];
  logic [1:0] m_bank = 2'b00;
  logic [1:0] m_kn   = 2'b00;

  always #4 clk = ~clk;

  spi_cmd_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
    .mosi_byte(mosi_byte), .miso_byte(miso_byte), .res_valid(res_valid),
    .res_opcode(res_opcode), .res_addr(res_addr), .res_data(res_data),
    .res_count(res_count), .bank(bank), .bank_known(bank_known),
    .warn_unknown_op(warn_unknown_op), .warn_bad_header(warn_bad_header),
    .warn_bad_length(warn_bad_length), .warn_bank_unknown(warn_bank_unknown)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_frame(input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      mosi_byte  = fm[i];
      miso_byte  = fs[i];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_frame(input int n);
    logic [7:0] h;
    logic [2:0] op;
    logic [7:0] e_data;
    bit e_unk, e_hdr, e_len_ok, e_reg, e_bu, hit;
    int e_cnt;
    string dtag, btag;
    h  = fm[0];
    op = h[7:5];
    e_cnt = (n > 255) ? 255 : n;
    e_unk = (op == 3'b110);
    e_hdr = ((op == 3'b001) && (h != 8'h3A)) || ((op == 3'b011) && (h != 8'h7A));
    case (op)
      3'b000: e_len_ok = (n == 2) || (n == 3);
      3'b010, 3'b100, 3'b101: e_len_ok = (n == 2);
      3'b111: e_len_ok = (n == 1);
      default: e_len_ok = 1'b1;
    endcase
    case (op)
      3'b000: e_data = (n >= 3) ? fs[2] : ((n == 2) ? fs[1] : 8'h00);
      3'b001: e_data = (n >= 2) ? fs[1] : 8'h00;
      3'b010, 3'b011, 3'b100, 3'b101: e_data = (n >= 2) ? fm[1] : 8'h00;
      default: e_data = 8'h00;
    endcase
    dtag = (op == 3'b000 || op == 3'b001) ? "R5" : "R6";
    e_reg = e_len_ok && (op == 3'b000 || op == 3'b010 || op == 3'b100 || op == 3'b101);
    e_bu  = e_reg && (m_kn != 2'b11);
    hit   = e_len_ok && (h[4:0] == 5'h1F);
    btag  = !e_len_ok ? "R13" : ((op == 3'b100 || op == 3'b101) ? "R8" : "R7");
    if (hit && op == 3'b010) begin
      m_bank = fm[1][1:0];
      m_kn   = 2'b11;
    end else if (hit && op == 3'b100) begin
      m_bank = m_bank | fm[1][1:0];
      m_kn   = m_kn | fm[1][1:0];
    end else if (hit && op == 3'b101) begin
      m_bank = m_bank & ~fm[1][1:0];
      m_kn   = m_kn | fm[1][1:0];
    end
    do_frame(n);
    chk(res_valid == 1'b1, "R12 pulse", int'(res_valid), 1);
    chk({res_opcode, res_addr} == h, "R1 opcode/addr", int'({res_opcode, res_addr}), int'(h));
    chk(warn_unknown_op == e_unk, "R2 unknown", int'(warn_unknown_op), int'(e_unk));
    chk(warn_bad_header == e_hdr, "R3 header", int'(warn_bad_header), int'(e_hdr));
    chk(warn_bad_length == !e_len_ok, "R4 length", int'(warn_bad_length), int'(!e_len_ok));
    chk(res_data == e_data, dtag, int'(res_data), int'(e_data));
    chk(int'(res_count) == e_cnt, "R11 count", int'(res_count), e_cnt);
    chk(warn_bank_unknown == e_bu, "R9 bank warn", int'(warn_bank_unknown), int'(e_bu));
    chk(bank == m_bank, btag, int'(bank), int'(m_bank));
    chk(bank_known == (m_kn == 2'b11), btag, int'(bank_known), int'(m_kn == 2'b11));
    @(negedge clk);
    chk(res_valid == 1'b0, "R12 one cycle", int'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R12 reset", int'(res_valid), 0);
    chk(bank_known == 1'b0, "R9 reset", int'(bank_known), 0);

    // R10: empty frame
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 empty frame", int'(res_valid), 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 empty frame", int'(res_valid), 0);

    // R8: partial knowledge via clear-bits, then set-bits completes it
    fm[0] = 8'hBF; fm[1] = 8'h02; fs[0] = 8'h00; fs[1] = 8'h00;
    check_frame(2);
    chk(bank_known == 1'b0, "R8 partial", int'(bank_known), 0);
    fm[0] = 8'h9F; fm[1] = 8'h01;
    check_frame(2);
    chk(bank == 2'd1, "R8 set", int'(bank), 1);

    // R13: bad-length load leaves bank alone
    fm[0] = 8'h5F; fm[1] = 8'h02; fm[2] = 8'h00;
    check_frame(3);
    chk(bank == 2'd1, "R13 no update", int'(bank), 1);

    // R12: stray strobe with cs_n high is ignored
    @(negedge clk);
    byte_valid = 1'b1; mosi_byte = 8'h55;
    @(negedge clk);
    byte_valid = 1'b0;
    fm[0] = 8'hE0;
    check_frame(1);
    chk(res_count == 8'd1, "R12 stray strobe", int'(res_count), 1);

    // R11: long buffer transfer saturates
    for (int i = 0; i < 300; i++) begin
      fm[i] = (i == 0) ? 8'h7A : 8'(i);
      fs[i] = 8'(i * 3);
    end
    check_frame(300);

    // Sweep every header across lengths 1..4
    for (int h = 0; h < 256; h++) begin
      for (int n = 1; n <= 4; n++) begin
        fm[0] = 8'(h);
        for (int i = 1; i < 4; i++) begin
          fm[i] = 8'(h * 7 + n * 3 + i);
          fs[i] = 8'(8'hA0 + i * 13 + h);
        end
        fs[0] = 8'hFF;
        check_frame(n);
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule